// File: doc/BRIEF.md
# Read-Data Bit Population Monitor

This block watches the byte stream of one flash read and keeps two running totals: how many one bits have gone past and how many zero bits have gone past. A start pulse opens a read and clears both totals. Each byte marked valid adds its one-bit count to the first total and the rest of its width to the second. An end pulse closes the read. At that point each total is compared against one shared threshold, and the result is latched into a flag.

Each flag reads 1 when its total is at or below the threshold. A controller reads the ones flag to spot a page that is almost all zeros. It reads the zeros flag to spot an erased or nearly blank page, where almost every bit reads as one. The flags only carry meaning while the statistics enable input is high; while it is low they are held at 0. Both raw totals are also brought out, so the exact figures can be read.

Top module: `rd_bitpop_monitor`

## Requirements
- R1: After synchronous reset, both counts and both flags read 0.
- R2: A byte with `rd_valid` high adds the number of one bits in `rd_data` to `ones_cnt`, visible one clock after the sampling edge. Data presented while `rd_valid` is low changes neither count.
- R3: A byte with `rd_valid` high adds 8 minus its one-bit count to `zeros_cnt` on the same edge as R2. Below saturation, the sum of the two counts grows by exactly 8 per valid byte.
- R4: `rd_start` clears both counts. If a valid byte arrives in the same cycle as `rd_start`, that byte becomes the first contribution of the new read.
- R5: On an edge where `rd_end` is high and `stat_en` is high, `ones_le` becomes 1 when the final ones count is less than or equal to `thresh`, and 0 otherwise. The final count includes a valid byte presented in that same cycle.
- R6: On the same edge, `zeros_le` becomes 1 when the final zeros count is less than or equal to `thresh`, and 0 otherwise.
- R7: While `stat_en` is high, the flags change only on an `rd_end` edge. Changing `thresh`, or sending further bytes, leaves them untouched until the next end.
- R8: Any edge with `stat_en` low drives both flags to 0, including an `rd_end` edge. After enable returns, the flags stay 0 until the next `rd_end`. The counts keep accumulating regardless of `stat_en`.
- R9: Each count saturates at 2^18-1 (262143) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | Start-of-read pulse; clears both counts |
| rd_valid | input | 1 | Qualifies `rd_data` this cycle |
| rd_data | input | 8 | Read data byte |
| rd_end | input | 1 | End-of-read pulse; latches the flags |
| stat_en | input | 1 | Statistics enable; flags forced to 0 while low |
| thresh | input | 18 | Shared threshold for both comparisons |
| ones_le | output | 1 | Ones count at or below threshold at last end |
| zeros_le | output | 1 | Zeros count at or below threshold at last end |
| ones_cnt | output | 18 | Running count of one bits in this read |
| zeros_cnt | output | 18 | Running count of zero bits in this read |

## Verification
Mixed bytes such as 0xFF, 0x00, 0xA5 and 0x01 tell a correct population count apart from one that counts bytes or a single bit lane. Gaps in which the data changes but the strobe stays low show that unqualified data is ignored. Runs of all-ones ending exactly at, or one above, the threshold pin down the "less than or equal" edge of each comparison, and an end pulse paired with a final byte shows whether that byte reaches the flags. Long runs of 0xFF and 0x00 push each counter past its ceiling, which separates saturation from wrap-around.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam int unsigned RBM_DATA_W = 8;
  localparam int unsigned RBM_CNT_W  = 18;
  localparam int unsigned RBM_CHANS  = 2;
  // channel index: 0 counts ones, 1 counts zeros
  typedef enum logic {CH_ONES = 1'b0, CH_ZEROS = 1'b1} rbm_chan_e;
endpackage

// File: rtl/rbm_popcount.sv
module rbm_popcount #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PW    = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data,
  output logic [PW-1:0]     ones
);
  logic [PW-1:0] part [DATA_W+1];

  assign part[0] = '0;
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign part[i+1] = part[i] + PW'(data[i]);
  end
  assign ones = part[DATA_W];
endmodule

// File: rtl/rbm_sat_counter.sv
module rbm_sat_counter #(
  parameter int unsigned CNT_W = 18,
  parameter int unsigned INC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] sat;

  assign sum = {1'b0, cnt} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
  assign sat = sum[CNT_W] ? MAXV : sum[CNT_W-1:0];

  always_comb begin
    if (clr)      cnt_nxt = add ? {{(CNT_W - INC_W){1'b0}}, inc} : '0;
    else if (add) cnt_nxt = sat;
    else          cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end
endmodule

// File: rtl/rbm_le_flag.sv
module rbm_le_flag #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             eval,
  input  logic [CNT_W-1:0] val,
  input  logic [CNT_W-1:0] thresh,
  output logic             flag
);
  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (!en)  flag <= 1'b0;
    else if (eval) flag <= (val <= thresh);
  end
endmodule

// File: rtl/rd_bitpop_monitor.sv
module rd_bitpop_monitor
  import rbm_pkg::*;
#(
  parameter int unsigned DATA_W = RBM_DATA_W,
  parameter int unsigned CNT_W  = RBM_CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_start,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_end,
  input  logic              stat_en,
  input  logic [CNT_W-1:0]  thresh,
  output logic              ones_le,
  output logic              zeros_le,
  output logic [CNT_W-1:0]  ones_cnt,
  output logic [CNT_W-1:0]  zeros_cnt
);
  localparam int unsigned PW = $clog2(DATA_W + 1);
  localparam logic [PW-1:0] WIDTH_C = PW'(DATA_W);

  logic [PW-1:0]    pop;
  logic [PW-1:0]    inc  [RBM_CHANS];
  logic [CNT_W-1:0] cnt  [RBM_CHANS];
  logic [CNT_W-1:0] nxt  [RBM_CHANS];
  logic             flg  [RBM_CHANS];

  rbm_popcount #(.DATA_W(DATA_W)) u_pop (
    .data (rd_data),
    .ones (pop)
  );

  for (genvar c = 0; c < RBM_CHANS; c++) begin : g_chan
    if (c == int'(CH_ONES)) begin : g_inc_one
      assign inc[c] = pop;
    end else begin : g_inc_zero
      assign inc[c] = WIDTH_C - pop;
    end

    rbm_sat_counter #(.CNT_W(CNT_W), .INC_W(PW)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .clr     (rd_start),
      .add     (rd_valid),
      .inc     (inc[c]),
      .cnt     (cnt[c]),
      .cnt_nxt (nxt[c])
    );

    rbm_le_flag #(.CNT_W(CNT_W)) u_flag (
      .clk    (clk),
      .rst    (rst),
      .en     (stat_en),
      .eval   (rd_end),
      .val    (nxt[c]),
      .thresh (thresh),
      .flag   (flg[c])
    );
  end

  assign ones_cnt  = cnt[int'(CH_ONES)];
  assign zeros_cnt = cnt[int'(CH_ZEROS)];
  assign ones_le   = flg[int'(CH_ONES)];
  assign zeros_le  = flg[int'(CH_ZEROS)];
endmodule

// File: rtl/rbm_checker.sv
module rbm_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_start,
  input logic              rd_valid,
  input logic              rd_end,
  input logic              stat_en,
  input logic [CNT_W-1:0]  thresh,
  input logic              ones_le,
  input logic              zeros_le,
  input logic [CNT_W-1:0]  ones_cnt,
  input logic [CNT_W-1:0]  zeros_cnt
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] LIM  = MAXV - CNT_W'(DATA_W);

  logic [CNT_W:0] total;
  assign total = {1'b0, ones_cnt} + {1'b0, zeros_cnt};

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!rd_start && !rd_valid) |=> ($stable(ones_cnt) && $stable(zeros_cnt)));

  p_byte_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_start && ones_cnt <= LIM && zeros_cnt <= LIM)
      |=> (total == $past(total) + (CNT_W + 1)'(DATA_W)));

  p_start_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_start && !rd_valid) |=> (ones_cnt == '0 && zeros_cnt == '0));

  p_ones_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_end && stat_en) |=> (ones_le == (ones_cnt <= $past(thresh))));

  p_zeros_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_end && stat_en) |=> (zeros_le == (zeros_cnt <= $past(thresh))));

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!rd_end && stat_en) |=> ($stable(ones_le) && $stable(zeros_le)));

  p_en_low_r8: assert property (@(posedge clk) disable iff (rst)
    (!stat_en) |=> (!ones_le && !zeros_le));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (!rd_start) |=> (ones_cnt >= $past(ones_cnt) && zeros_cnt >= $past(zeros_cnt)));
endmodule

bind rd_bitpop_monitor rbm_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_start  (rd_start),
  .rd_valid  (rd_valid),
  .rd_end    (rd_end),
  .stat_en   (stat_en),
  .thresh    (thresh),
  .ones_le   (ones_le),
  .zeros_le  (zeros_le),
  .ones_cnt  (ones_cnt),
  .zeros_cnt (zeros_cnt)
);

// File: tb/sim_rd_bitpop_monitor.sv
module sim_rd_bitpop_monitor;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 18;
  localparam int MAXC   = (1 << CNT_W) - 1;

  typedef struct {
    int    ones;
    int    zeros;
    bit    fo;
    bit    fz;
    string req;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rd_start = 1'b0;
  logic              rd_valid = 1'b0;
  logic [DATA_W-1:0] rd_data = '0;
  logic              rd_end = 1'b0;
  logic              stat_en = 1'b1;
  logic [CNT_W-1:0]  thresh = '0;
  logic              ones_le, zeros_le;
  logic [CNT_W-1:0]  ones_cnt, zeros_cnt;

  int   n_tests = 0;
  int   n_fail  = 0;
  exp_t exp_q[$];

  int m_ones = 0, m_zeros = 0;
  bit m_fo = 1'b0, m_fz = 1'b0;

  always #10 clk = ~clk;

  rd_bitpop_monitor u0 (
    .clk(clk), .rst(rst), .rd_start(rd_start), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_end(rd_end), .stat_en(stat_en), .thresh(thresh),
    .ones_le(ones_le), .zeros_le(zeros_le), .ones_cnt(ones_cnt), .zeros_cnt(zeros_cnt)
  );

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic push_exp(input string req);
    exp_t e;
    e.ones = m_ones; e.zeros = m_zeros; e.fo = m_fo; e.fz = m_fz; e.req = req;
    exp_q.push_back(e);
  endtask

  // driver: called just after a falling edge; applies one cycle of stimulus
  task automatic step(input bit st, input bit vl, input logic [7:0] d,
                      input bit en_, input bit chk, input string req);
    int p;
    p = $countones(d);
    rd_start = st; rd_valid = vl; rd_data = d; rd_end = en_;
    if (st) begin
      m_ones  = vl ? p : 0;
      m_zeros = vl ? DATA_W - p : 0;
    end else if (vl) begin
      m_ones  = sat(m_ones + p);
      m_zeros = sat(m_zeros + DATA_W - p);
    end
    if (!stat_en) begin
      m_fo = 1'b0; m_fz = 1'b0;
    end else if (en_) begin
      m_fo = (m_ones <= int'(thresh));
      m_fz = (m_zeros <= int'(thresh));
    end
    @(negedge clk);
    rd_start = 1'b0; rd_valid = 1'b0; rd_end = 1'b0;
    if (chk) push_exp(req);
  endtask

  // monitor: compares design outputs with queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_tests++;
        if (int'(ones_cnt) != e.ones) begin
          n_fail++;
          $display("FAIL %s ones_cnt actual=%0d expected=%0d", e.req, ones_cnt, e.ones);
        end
        if (int'(zeros_cnt) != e.zeros) begin
          n_fail++;
          $display("FAIL %s zeros_cnt actual=%0d expected=%0d", e.req, zeros_cnt, e.zeros);
        end
        if (ones_le != e.fo) begin
          n_fail++;
          $display("FAIL %s ones_le actual=%0b expected=%0b", e.req, ones_le, e.fo);
        end
        if (zeros_le != e.fz) begin
          n_fail++;
          $display("FAIL %s zeros_le actual=%0b expected=%0b", e.req, zeros_le, e.fz);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    push_exp("R1 reset state");
    @(negedge clk);

    // R2 R3: mixed bytes, gaps with changing data but no strobe
    thresh = 18'd10;
    step(1, 0, 8'h00, 0, 1, "R4 start clears");
    step(0, 1, 8'hFF, 0, 1, "R2 R3 byte FF");
    step(0, 0, 8'hFF, 0, 1, "R2 unqualified data ignored");
    step(0, 1, 8'h00, 0, 1, "R2 R3 byte 00");
    step(0, 1, 8'hA5, 0, 1, "R2 R3 byte A5");
    step(0, 0, 8'h7E, 0, 1, "R2 unqualified data ignored");
    step(0, 1, 8'h01, 0, 1, "R2 R3 byte 01");
    step(0, 0, 8'h00, 1, 1, "R5 R6 end above threshold");

    // R5 R6: end with final byte, threshold exactly at ones count
    thresh = 18'd32;
    step(1, 1, 8'hFF, 0, 1, "R4 start with byte");
    step(0, 1, 8'hFF, 0, 0, "");
    step(0, 1, 8'hFF, 0, 0, "");
    step(0, 1, 8'hFF, 1, 1, "R5 R6 end with final byte at threshold");
    thresh = 18'd31;
    step(1, 1, 8'hFF, 0, 0, "");
    step(0, 1, 8'hFF, 0, 0, "");
    step(0, 1, 8'hFF, 0, 0, "");
    step(0, 1, 8'hFF, 1, 1, "R5 one above threshold");

    // R7: flags hold while threshold and data move
    thresh = 18'd200;
    step(0, 0, 8'h00, 0, 1, "R7 threshold change no effect");
    step(0, 1, 8'h00, 0, 1, "R7 new byte no flag change");
    step(1, 1, 8'h0F, 0, 1, "R4 R7 start with byte flags held");
    step(0, 0, 8'h00, 1, 1, "R5 R6 both at or below");

    // R8: enable low
    stat_en = 1'b0;
    step(0, 0, 8'h00, 0, 1, "R8 enable low clears flags");
    step(0, 1, 8'hF0, 1, 1, "R8 end while disabled, counts still move");
    stat_en = 1'b1;
    step(0, 0, 8'h00, 0, 1, "R8 flags stay 0 until end");
    step(0, 0, 8'h00, 1, 1, "R5 R6 end after re-enable");

    // R9: ones saturation
    thresh = 18'h3FFFF;
    step(1, 0, 8'h00, 0, 0, "");
    for (int i = 0; i < 32770; i++) step(0, 1, 8'hFF, 0, 0, "");
    step(0, 0, 8'h00, 1, 1, "R9 ones saturate");
    // R9: zeros saturation
    thresh = 18'd1000;
    step(1, 0, 8'h00, 0, 0, "");
    for (int i = 0; i < 32770; i++) step(0, 1, 8'h00, 0, 0, "");
    step(0, 0, 8'h00, 1, 1, "R9 zeros saturate");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule